// File: doc/BRIEF.md
# SPI master with one-byte transmit queue

This block is the controller end of a serial peripheral link. It moves 8-bit words in both directions at once. A host reaches it through a small register port with three addresses: control, status and data. A write to the data address places a byte in a one-entry holding register. The shifter takes the byte from there as soon as it is idle. It also takes the byte at the exact bit slot where the previous byte finishes, so a host that refills the holder in time gets a continuous serial stream with no gap.

The serial clock is made from the system clock by a programmable divider. The control register selects the clock idle level and the sampling phase. The block watches an active-low select input. If another controller drives that input while this one is enabled, the block stops at once and disables itself. It then flags the conflict until the host acknowledges it. An interrupt line is raised for a completed byte and for a conflict.

Top module: `spi_qmaster`

Register map: address 0 is control, with bit 0 enable, bit 1 clock idle level (CPOL), bit 2 phase (CPHA) and bits [7:3] divider code D. Address 1 is status, with bit 0 holder free, bit 1 byte complete, bit 2 mode fault, bit 3 busy, and upper bits zero. A write to address 2 fills the holder and a read of it returns the last received byte. Address 3 reads zero.

## Requirements
- R1: After reset, control reads 0, status reads 0x01, SCK is low and the interrupt is low.
- R2: Each byte goes out on MOSI most significant bit first. MISO bits are shifted in the same order into the received byte read at address 2. Every SCK level lasts D+1 system clocks.
- R3: A byte written to the holder while a byte is shifting starts on the next bit slot. All SCK edges of such a burst are evenly spaced D+1 clocks apart, with no idle gap between bytes.
- R4: Status bit 0 is 1 while the holder is free and drops when the host writes address 2 while enabled. It returns to 1 when the shifter takes the byte. A data write while disabled is ignored and starts no transfer.
- R5: Whenever no byte is shifting, SCK stays at the level of the CPOL bit.
- R6: With CPHA 0, the first data bit is valid before the first edge and MISO is sampled on leading edges. With CPHA 1, data change on leading edges and MISO is sampled on trailing edges.
- R7: Status bit 1 is set when a byte completes and drives the interrupt. A status read clears it. A completion in the same cycle as a status read leaves it set.
- R8: The select input going low while enabled sets status bit 2 and raises the interrupt. It also clears the enable bit, aborts the byte in flight, returns SCK to idle and empties the holder.
- R9: The fault flag clears only on a control write that follows a status read made while it was set. That clearing write cannot set enable. While the flag is set, enable reads 0 whatever is written.
- R10: The select input has no effect while the block is disabled.
- R11: Status bit 3 is 1 while a byte is shifting and 0 when the link is idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe (status read side effects) |
| bus_addr | input | 2 | Register address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, combinational from the address |
| irq | output | 1 | Interrupt: byte complete or mode fault |
| sck | output | 1 | Serial clock |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |
| ss_n | input | 1 | Active-low select input watched for a conflicting controller |

## Verification
Two pairs of events can land on one clock edge. A byte can complete on the same edge as a status read, and the holder can be refilled on the edge where the shifter takes its byte. The bench provokes the first pair on purpose. It writes one byte, counts exactly sixteen half periods and puts the status read strobe on the completion edge. The read must show the flag clear, and the following read must show it set. The second pair arises in every queued burst, where the host refills the holder as soon as it frees. There the serial slave model must capture every byte in order, and no spacing between SCK edges may differ from D+1 clocks.

// File: rtl/spi_qm_pkg.sv
package spi_qm_pkg;
  // control field positions
  localparam int CTRL_EN      = 0;
  localparam int CTRL_CPOL    = 1;
  localparam int CTRL_CPHA    = 2;
  localparam int CTRL_DIV_LSB = 3;
  // status field positions
  localparam int ST_TXE  = 0;
  localparam int ST_DONE = 1;
  localparam int ST_MODF = 2;
  localparam int ST_BUSY = 3;

  typedef enum logic [1:0] {
    A_CTRL = 2'd0,
    A_STAT = 2'd1,
    A_DATA = 2'd2,
    A_NONE = 2'd3
  } reg_addr_e;

  // SCK level for a running byte: second half of a bit slot is the active
  // level for phase 0, the first half for phase 1.
  function automatic logic sck_level(logic pol, logic pha, logic second_half);
    return pol ^ pha ^ second_half;
  endfunction
endpackage

// File: rtl/spi_qm_sync.sv
module spi_qm_sync #(
  parameter int   STAGES  = 2,
  parameter logic RST_VAL = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  generate
    if (STAGES <= 1) begin : g_single
      logic s_q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= RST_VAL;
        else        s_q <= d;
      end
      assign q = s_q;
    end else begin : g_chain
      logic [STAGES-1:0] chain_q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= {STAGES{RST_VAL}};
        else        chain_q <= {chain_q[STAGES-2:0], d};
      end
      assign q = chain_q[STAGES-1];
    end
  endgenerate
endmodule

// File: rtl/spi_qm_regs.sv
module spi_qm_regs
  import spi_qm_pkg::*;
#(
  parameter int DW   = 8,
  parameter int DIVW = 5
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            bus_wr,
  input  logic            bus_rd,
  input  logic [1:0]      bus_addr,
  input  logic [DW-1:0]   bus_wdata,
  output logic [DW-1:0]   bus_rdata,
  input  logic            ss_active,
  input  logic            take,
  input  logic            done_evt,
  input  logic            busy,
  input  logic [DW-1:0]   rx_data,
  output logic            en,
  output logic            cpol,
  output logic            cpha,
  output logic [DIVW-1:0] div,
  output logic            buf_full,
  output logic [DW-1:0]   buf_data,
  output logic            abort,
  output logic            irq
);
  logic en_q, cpol_q, cpha_q, full_q, done_q, modf_q, armed_q;
  logic [DIVW-1:0] div_q;
  logic [DW-1:0]   data_q;
  logic wr_ctrl, wr_data, rd_stat;

  assign wr_ctrl = bus_wr && (bus_addr == A_CTRL);
  assign wr_data = bus_wr && (bus_addr == A_DATA);
  assign rd_stat = bus_rd && (bus_addr == A_STAT);
  // a conflicting controller pulls select while this block is enabled
  assign abort   = en_q && ss_active;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q    <= 1'b0;
      cpol_q  <= 1'b0;
      cpha_q  <= 1'b0;
      div_q   <= '0;
      modf_q  <= 1'b0;
      armed_q <= 1'b0;
    end else begin
      if (abort) begin
        en_q    <= 1'b0;
        modf_q  <= 1'b1;
        armed_q <= 1'b0;
      end else if (wr_ctrl) begin
        en_q <= bus_wdata[CTRL_EN] & ~modf_q;
        if (armed_q) begin
          modf_q  <= 1'b0;
          armed_q <= 1'b0;
        end
      end else if (rd_stat && modf_q) begin
        armed_q <= 1'b1;
      end
      if (wr_ctrl) begin
        cpol_q <= bus_wdata[CTRL_CPOL];
        cpha_q <= bus_wdata[CTRL_CPHA];
        div_q  <= bus_wdata[CTRL_DIV_LSB +: DIVW];
      end
    end
  end

  // one-entry holding register
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      full_q <= 1'b0;
      data_q <= '0;
    end else if (abort) begin
      full_q <= 1'b0;
    end else if (wr_data && en_q) begin
      full_q <= 1'b1;
      data_q <= bus_wdata;
    end else if (take) begin
      full_q <= 1'b0;
    end
  end

  // completion flag: a new completion wins over a clearing read
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        done_q <= 1'b0;
    else if (done_evt) done_q <= 1'b1;
    else if (rd_stat)  done_q <= 1'b0;
  end

  always_comb begin
    bus_rdata = '0;
    case (bus_addr)
      A_CTRL: begin
        bus_rdata[CTRL_EN]                = en_q;
        bus_rdata[CTRL_CPOL]              = cpol_q;
        bus_rdata[CTRL_CPHA]              = cpha_q;
        bus_rdata[CTRL_DIV_LSB +: DIVW]   = div_q;
      end
      A_STAT: begin
        bus_rdata[ST_TXE]  = ~full_q;
        bus_rdata[ST_DONE] = done_q;
        bus_rdata[ST_MODF] = modf_q;
        bus_rdata[ST_BUSY] = busy;
      end
      A_DATA:  bus_rdata = rx_data;
      default: bus_rdata = '0;
    endcase
  end

  assign en       = en_q;
  assign cpol     = cpol_q;
  assign cpha     = cpha_q;
  assign div      = div_q;
  assign buf_full = full_q;
  assign buf_data = data_q;
  assign irq      = done_q | modf_q;

  a_r4_write_fills: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_data && en_q && !abort) |=> full_q);
  a_r7_done_wins: assert property (@(posedge clk) disable iff (!rst_n)
    done_evt |=> done_q);
  a_r8_fault_flushes: assert property (@(posedge clk) disable iff (!rst_n)
    abort |=> (modf_q && !full_q && !en_q));
  a_r9_enable_locked: assert property (@(posedge clk) disable iff (!rst_n)
    modf_q |-> !en_q);
  a_r10_ignored_disabled: assert property (@(posedge clk) disable iff (!rst_n)
    !en_q |=> !$rose(modf_q));
endmodule

// File: rtl/spi_qm_engine.sv
module spi_qm_engine
  import spi_qm_pkg::*;
#(
  parameter int DW   = 8,
  parameter int DIVW = 5
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            cpol,
  input  logic            cpha,
  input  logic [DIVW-1:0] div,
  input  logic            start_req,
  input  logic [DW-1:0]   start_data,
  input  logic            abort,
  input  logic            miso,
  output logic            sck,
  output logic            mosi,
  output logic            busy,
  output logic            take,
  output logic            done_evt,
  output logic [DW-1:0]   rx_data
);
  localparam int BW = (DW > 1) ? $clog2(DW) : 1;
  localparam logic [BW-1:0] LAST_BIT = BW'(DW - 1);

  logic            run_q, half_q, sck_q;
  logic [BW-1:0]   bit_q;
  logic [DIVW-1:0] cnt_q;
  logic [DW-1:0]   tx_q, rx_sh_q, rx_q;
  logic            tick, start, byte_end, cont;

  function automatic logic slot_over(logic [DIVW-1:0] cnt, logic [DIVW-1:0] lim);
    return cnt == lim;
  endfunction

  function automatic logic [DW-1:0] shift_in(logic [DW-1:0] cur, logic b);
    return {cur[DW-2:0], b};
  endfunction

  assign tick     = run_q && slot_over(cnt_q, div);
  assign start    = !run_q && start_req && !abort;
  assign byte_end = tick && half_q && (bit_q == LAST_BIT);
  assign cont     = byte_end && start_req && !abort;
  assign take     = start || cont;
  assign done_evt = byte_end && !abort;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q   <= 1'b0;
      half_q  <= 1'b0;
      bit_q   <= '0;
      cnt_q   <= '0;
      tx_q    <= '0;
      rx_sh_q <= '0;
      rx_q    <= '0;
      sck_q   <= 1'b0;
    end else if (abort) begin
      run_q  <= 1'b0;
      half_q <= 1'b0;
      bit_q  <= '0;
      cnt_q  <= '0;
      sck_q  <= cpol;
    end else if (start) begin
      run_q  <= 1'b1;
      half_q <= 1'b0;
      bit_q  <= '0;
      cnt_q  <= '0;
      tx_q   <= start_data;
      sck_q  <= sck_level(cpol, cpha, 1'b0);
    end else if (run_q) begin
      if (tick) begin
        cnt_q <= '0;
        if (!half_q) begin
          half_q  <= 1'b1;
          rx_sh_q <= shift_in(rx_sh_q, miso);
          sck_q   <= sck_level(cpol, cpha, 1'b1);
        end else begin
          half_q <= 1'b0;
          if (bit_q == LAST_BIT) begin
            rx_q <= rx_sh_q;
            if (cont) begin
              tx_q  <= start_data;
              bit_q <= '0;
              sck_q <= sck_level(cpol, cpha, 1'b0);
            end else begin
              run_q <= 1'b0;
              sck_q <= cpol;
            end
          end else begin
            bit_q <= bit_q + BW'(1);
            tx_q  <= {tx_q[DW-2:0], 1'b0};
            sck_q <= sck_level(cpol, cpha, 1'b0);
          end
        end
      end else begin
        cnt_q <= cnt_q + DIVW'(1);
      end
    end else begin
      sck_q <= cpol;
    end
  end

  assign sck     = sck_q;
  assign mosi    = tx_q[DW-1];
  assign busy    = run_q;
  assign rx_data = rx_q;

  a_r2_sck_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (run_q && !tick && !abort) |=> $stable(sck_q));
  a_r3_no_gap: assert property (@(posedge clk) disable iff (!rst_n)
    cont |=> (run_q && !half_q && (bit_q == '0)));
  a_r5_idle_level: assert property (@(posedge clk) disable iff (!rst_n)
    (!run_q && $stable(cpol)) |-> (sck_q == cpol));
  a_r8_abort_stops: assert property (@(posedge clk) disable iff (!rst_n)
    abort |=> (!run_q && (sck_q == $past(cpol))));
endmodule

// File: rtl/spi_qmaster.sv
module spi_qmaster
  import spi_qm_pkg::*;
#(
  parameter int DW        = 8,
  parameter int DIVW      = 5,
  parameter int SS_STAGES = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bus_wr,
  input  logic          bus_rd,
  input  logic [1:0]    bus_addr,
  input  logic [DW-1:0] bus_wdata,
  output logic [DW-1:0] bus_rdata,
  output logic          irq,
  output logic          sck,
  output logic          mosi,
  input  logic          miso,
  input  logic          ss_n
);
  logic            ss_sync, en, cpol, cpha, buf_full, abort;
  logic            take, done_evt, busy;
  logic [DIVW-1:0] div;
  logic [DW-1:0]   buf_data, rx_data;

  spi_qm_sync #(.STAGES(SS_STAGES), .RST_VAL(1'b1)) u_ss_sync (
    .clk(clk), .rst_n(rst_n), .d(ss_n), .q(ss_sync)
  );

  spi_qm_regs #(.DW(DW), .DIVW(DIVW)) u_regs (
    .clk(clk), .rst_n(rst_n),
    .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .ss_active(~ss_sync), .take(take), .done_evt(done_evt), .busy(busy),
    .rx_data(rx_data), .en(en), .cpol(cpol), .cpha(cpha), .div(div),
    .buf_full(buf_full), .buf_data(buf_data), .abort(abort), .irq(irq)
  );

  spi_qm_engine #(.DW(DW), .DIVW(DIVW)) u_engine (
    .clk(clk), .rst_n(rst_n), .cpol(cpol), .cpha(cpha), .div(div),
    .start_req(buf_full && en), .start_data(buf_data), .abort(abort),
    .miso(miso), .sck(sck), .mosi(mosi), .busy(busy), .take(take),
    .done_evt(done_evt), .rx_data(rx_data)
  );
endmodule

// File: tb/spi_qmaster_tb.sv
`timescale 1ns/1ps
module spi_qmaster_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       bus_wr = 1'b0, bus_rd = 1'b0;
  logic [1:0] bus_addr = 2'd0;
  logic [7:0] bus_wdata = 8'd0;
  logic [7:0] bus_rdata;
  logic       irq, sck, mosi;
  logic       miso = 1'b0;
  logic       ss_n = 1'b1;

  int tests = 0, fails = 0, cyc = 0;
  logic last_irq;

  // slave model state
  bit        mon_on = 1'b0;
  logic      m_cpol = 1'b0, m_cpha = 1'b0;
  time       half_ns = 20, prev_t = 0;
  bit        have_prev = 1'b0;
  int        gap_err = 0, sb = 0, cap_bits = 0;
  logic [7:0] cap = 8'd0, salt = 8'd0;
  logic [7:0] cap_bytes [0:7];
  logic [7:0] tx_bytes  [0:7];

  spi_qmaster u_dut (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .irq(irq), .sck(sck), .mosi(mosi), .miso(miso), .ss_n(ss_n)
  );

  always #10 clk = ~clk;

  function automatic logic [7:0] slave_byte(int k);
    return salt ^ 8'((k * 29) + 7);
  endfunction

  function automatic logic slave_bit(int b);
    logic [7:0] w;
    w = slave_byte(b / 8);
    return w[7 - (b % 8)];
  endfunction

  function automatic logic [7:0] ctrl_word(logic ena, logic pol, logic pha, logic [4:0] dv);
    return {dv, pha, pol, ena};
  endfunction

  always @(posedge clk) begin
    cyc++;
    if (cyc == 150000) begin
      tests++; fails++;
      $display("FAIL watchdog (all requirements): actual cycles=%0d expected fewer", cyc);
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  // serial slave: sample on leading edges for phase 0, trailing for phase 1
  always @(sck) begin
    if (mon_on) begin
      logic lead;
      if (have_prev && (($time - prev_t) != half_ns)) gap_err++;
      prev_t = $time;
      have_prev = 1'b1;
      lead = (sck != m_cpol);
      if (lead == !m_cpha) begin
        cap = {cap[6:0], mosi};
        cap_bits++;
        if ((cap_bits % 8) == 0 && (cap_bits / 8) <= 8) cap_bytes[cap_bits/8 - 1] = cap;
        if (m_cpha) sb++;
      end
      if (!m_cpha && !lead) begin
        sb++;
        miso = slave_bit(sb);
      end
      if (m_cpha && lead) miso = slave_bit(sb);
    end
  end

  task automatic slave_reset();
    sb = 0; cap_bits = 0; cap = 8'd0; gap_err = 0; have_prev = 1'b0;
    miso = slave_bit(0);
    mon_on = 1'b1;
  endtask

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(posedge clk); #1;
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk);
    bus_rd = 1'b1; bus_addr = a;
    #1 d = bus_rdata; last_irq = irq;
    @(posedge clk); #1;
    bus_rd = 1'b0;
  endtask

  task automatic run_burst(input int n, input logic pol, input logic pha, input logic [4:0] dv);
    logic [7:0] v;
    mon_on = 1'b0;
    wr(2'd0, ctrl_word(1'b1, pol, pha, dv));
    repeat (2) @(posedge clk); #1;
    chk("R5 idle SCK before burst", 32'(sck), 32'(pol));
    m_cpol = pol; m_cpha = pha;
    half_ns = time'(dv + 1) * 20;
    salt = 8'($urandom);
    slave_reset();
    wr(2'd2, tx_bytes[0]);
    for (int i = 1; i < n; i++) begin
      do rd(2'd1, v); while (!v[0]);
      wr(2'd2, tx_bytes[i]);
    end
    do rd(2'd1, v); while (v[3] || !v[0]);
    chk("R7 done seen with idle link", 32'(v), 32'h03);
    chk("R7 irq with done", 32'(last_irq), 32'd1);
    chk("R7 irq after status read", 32'(irq), 32'd0);
    chk("R2 MOSI bit count", 32'(cap_bits), 32'(n * 8));
    for (int i = 0; i < n; i++)
      chk("R2 MOSI byte order", 32'(cap_bytes[i]), 32'(tx_bytes[i]));
    rd(2'd2, v);
    chk("R2 R6 received byte", 32'(v), 32'(slave_byte(n - 1)));
    chk("R3 edge spacing errors", 32'(gap_err), 32'd0);
    chk("R5 idle SCK after burst", 32'(sck), 32'(pol));
    mon_on = 1'b0;
  endtask

  initial begin
    logic [7:0] v;
    void'($urandom(32'd4242));
    repeat (4) @(posedge clk); #1;
    rst_n = 1'b1;

    // R1 reset state
    rd(2'd0, v); chk("R1 control reset", 32'(v), 32'h00);
    rd(2'd1, v); chk("R1 status reset", 32'(v), 32'h01);
    chk("R1 SCK reset", 32'(sck), 32'd0);
    chk("R1 irq reset", 32'(irq), 32'd0);

    // R4 data write while disabled is dropped
    wr(2'd2, 8'h77);
    rd(2'd1, v); chk("R4 disabled write ignored", 32'(v), 32'h01);
    wr(2'd0, ctrl_word(1'b1, 1'b0, 1'b0, 5'd2));
    repeat (40) @(posedge clk);
    rd(2'd1, v); chk("R4 no transfer after enable", 32'(v), 32'h01);

    // directed bursts in every mode
    tx_bytes[0] = 8'hC3; tx_bytes[1] = 8'h5A; tx_bytes[2] = 8'h0F;
    for (int m = 0; m < 4; m++) run_burst(3, m[1], m[0], 5'd1);
    tx_bytes[0] = 8'h96;
    run_burst(1, 1'b0, 1'b0, 5'd0);

    // R11 busy while shifting
    wr(2'd0, ctrl_word(1'b1, 1'b0, 1'b0, 5'd3));
    wr(2'd2, 8'hA1);
    @(posedge clk);
    rd(2'd1, v);
    chk("R11 busy during byte", 32'(v[3]), 32'd1);
    chk("R4 holder freed on start", 32'(v[0]), 32'd1);
    do rd(2'd1, v); while (v[3]);
    chk("R11 busy clear when idle", 32'(v[3]), 32'd0);

    // R7 completion on the same edge as a status read (H = 2)
    wr(2'd0, ctrl_word(1'b1, 1'b0, 1'b0, 5'd1));
    rd(2'd1, v);
    wr(2'd2, 8'h5A);
    repeat (32) @(posedge clk);
    rd(2'd1, v);
    chk("R7 collision read sees pre-edge done", 32'(v[1]), 32'd0);
    chk("R11 busy on completion edge", 32'(v[3]), 32'd1);
    rd(2'd1, v);
    chk("R7 done set wins over clear", 32'(v[1]), 32'd1);

    // R8 / R9 mode fault
    wr(2'd0, ctrl_word(1'b1, 1'b0, 1'b0, 5'd3));
    wr(2'd2, 8'hE7);
    wr(2'd2, 8'h3C);
    repeat (10) @(posedge clk);
    @(negedge clk) ss_n = 1'b0;
    repeat (5) @(posedge clk); #1;
    chk("R8 irq on fault", 32'(irq), 32'd1);
    chk("R8 SCK idle on fault", 32'(sck), 32'd0);
    rd(2'd0, v); chk("R8 enable cleared", 32'(v[0]), 32'd0);
    @(negedge clk) ss_n = 1'b1;
    repeat (3) @(posedge clk);
    wr(2'd0, ctrl_word(1'b1, 1'b0, 1'b0, 5'd3));
    rd(2'd0, v); chk("R9 enable refused while fault", 32'(v[0]), 32'd0);
    rd(2'd1, v); chk("R8 fault status, holder empty, idle", 32'(v), 32'h05);
    wr(2'd0, ctrl_word(1'b1, 1'b0, 1'b0, 5'd3));
    rd(2'd1, v); chk("R9 fault cleared by read then write", 32'(v), 32'h01);
    rd(2'd0, v); chk("R9 clearing write leaves enable low", 32'(v[0]), 32'd0);
    chk("R9 irq low after clear", 32'(irq), 32'd0);
    wr(2'd0, ctrl_word(1'b1, 1'b0, 1'b0, 5'd3));
    rd(2'd0, v); chk("R9 enable after clear", 32'(v[0]), 32'd1);

    // R10 select ignored while disabled
    wr(2'd0, ctrl_word(1'b0, 1'b0, 1'b0, 5'd3));
    @(negedge clk) ss_n = 1'b0;
    repeat (6) @(posedge clk);
    rd(2'd1, v); chk("R10 no fault while disabled", 32'(v), 32'h01);
    chk("R10 irq low while disabled", 32'(irq), 32'd0);
    @(negedge clk) ss_n = 1'b1;
    repeat (3) @(posedge clk);

    // constrained random bursts
    for (int b = 0; b < 24; b++) begin
      int n;
      n = 1 + int'($urandom % 4);
      for (int i = 0; i < n; i++) tx_bytes[i] = 8'($urandom);
      run_burst(n, ($urandom & 1) != 0, ($urandom & 1) != 0, 5'($urandom % 4));
    end

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule